// File: doc/BRIEF.md
# Serial TDM Frame Generator

This block is the transmit half of the controller end of a five-wire audio link. It runs on the incoming bit clock and counts bit periods to mark out fixed frames of 256 bits. It drives a frame SYNC strobe and shifts out one serial frame per period. Each frame opens with a 16-bit tag slot and continues with twelve 20-bit data slots.

The user supplies two command words (register address and register data) and four PCM playback words. Each word comes with its own valid flag. The block captures all of them once per frame, right before the frame begins. From the flags it builds the tag slot, places each word in its fixed slot, and drives zeros in every slot that is not valid or not used. A one-cycle `frameStart` strobe marks the first bit of each frame. After this strobe the user may load the words for the next frame.

Serial data and SYNC change on the rising edge of `bitClk`, so a receiver can sample them on the falling edge.

Top module: `tdm_frame_tx`

## Requirements
- R1: A new frame begins every 256 bit clocks, and `frameStart` is high on the first bit of each frame.
- R2: `syncOut` is high for the first 16 bits of every frame (bit positions 0 to 15) and low for positions 16 to 255.
- R3: The first serial bit of a frame (tag bit 15) is 1 exactly when at least one of the six valid flags captured for that frame is set.
- R4: Tag bit 15-s (serial position s) carries the valid flag of slot s for s = 1..12. Slots 5, 7, 8, 10, 11 and 12 always tag 0. Tag bits 2 to 0 (positions 13 to 15) are 0.
- R5: Slot s occupies serial positions 16+20*(s-1) to 35+20*(s-1). Slot 1 carries the command address and slot 2 carries the command data, each sent MSB first.
- R6: PCM words 0, 1, 2 and 3 (pcmData bits [20k+19:20k] for word k) go out MSB first in slots 3, 4, 6 and 9.
- R7: Every bit of a slot whose flag is clear is 0, and so is every bit of the unused slots, whatever is on the data inputs.
- R8: Data and flags are captured at the rising edge that starts a frame. Input changes at any other time have no effect on the frame in progress.
- R9: `frameStart` is high for exactly one bit clock per frame.
- R10: While `rstN` is low, `syncOut`, `sdataOut` and `frameStart` are 0. The first frame starts at the first rising edge after `rstN` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Asynchronous active-low reset |
| bitClk | input | 1 | Serial bit clock |
| cmdAddr | input | 20 | Command address word (slot 1) |
| cmdAddrValid | input | 1 | Slot 1 carries data |
| cmdData | input | 20 | Command data word (slot 2) |
| cmdDataValid | input | 1 | Slot 2 carries data |
| pcmData | input | 80 | Four PCM words, word k at bits [20k+19:20k] |
| pcmValid | input | 4 | Valid flag per PCM word |
| syncOut | output | 1 | Frame sync, high during the tag slot |
| sdataOut | output | 1 | Serial frame data, MSB first |
| frameStart | output | 1 | Pulse on the first bit of each frame |

## Verification
The assertions assume the parallel inputs hold steady across the rising edge that starts a frame. That edge is the only point where they are captured, and at every other edge the inputs may change freely. The stimulus respects this assumption by changing inputs only on falling edges. It deliberately scrambles all data and flags just after `frameStart`, then loads the real words for the next frame in the middle of the current one. This shows that the frame in flight ignores both changes.

// File: rtl/tdm_frame_pkg.sv
package tdm_frame_pkg;
  localparam int TAG_W    = 16;
  localparam int SLOT_W   = 20;
  localparam int SLOT_CNT = 12;
  localparam int PCM_CH   = 4;

  // strobes from the sequencer into the shifter
  typedef struct packed {
    logic load;   // capture a fresh frame image
    logic shift;  // advance one serial bit
  } frameStrobe_t;

  // slot number that carries PCM word k
  function automatic int pcmSlot(input int k);
    case (k)
      0: return 3;
      1: return 4;
      2: return 6;
      default: return 9;
    endcase
  endfunction
endpackage

// File: rtl/tdm_frame_ctrl.sv
module tdm_frame_ctrl
  import tdm_frame_pkg::*;
#(
  parameter int TAG_BITS   = TAG_W,
  parameter int FRAME_BITS = TAG_W + SLOT_CNT * SLOT_W
) (
  input  logic         bitClk,
  input  logic         rstN,
  output frameStrobe_t strb,
  output logic         syncOut,
  output logic         frameStart
);
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_BITS - 1);

  logic [CNT_W-1:0] bitPos;
  logic [CNT_W-1:0] nextPos;
  logic             syncReg;

  assign nextPos = (bitPos == LAST_POS) ? '0 : bitPos + 1'b1;

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      bitPos  <= LAST_POS;
      syncReg <= 1'b0;
    end else begin
      bitPos  <= nextPos;
      syncReg <= (nextPos < CNT_W'(TAG_BITS));
    end
  end

  always_comb begin
    strb.load  = (bitPos == LAST_POS);
    strb.shift = !strb.load;
  end

  assign syncOut    = syncReg;
  assign frameStart = rstN && (bitPos == '0);

  a_r1_wrap: assert property (@(posedge bitClk) disable iff (!rstN)
    (bitPos == LAST_POS) |=> (bitPos == '0));
  a_r2_sync_rise: assert property (@(posedge bitClk) disable iff (!rstN)
    $rose(syncOut) |-> (bitPos == '0));
  a_r2_sync_fall: assert property (@(posedge bitClk) disable iff (!rstN)
    $fell(syncOut) |-> (bitPos == CNT_W'(TAG_BITS)));
  a_r9_start_in_sync: assert property (@(posedge bitClk) disable iff (!rstN)
    frameStart |-> syncOut);
  a_r9_single_pulse: assert property (@(posedge bitClk) disable iff (!rstN)
    frameStart |=> !frameStart);
endmodule

// File: rtl/tdm_frame_dp.sv
module tdm_frame_dp
  import tdm_frame_pkg::*;
#(
  parameter int TAG_BITS  = TAG_W,
  parameter int SLOT_BITS = SLOT_W,
  parameter int NUM_SLOTS = SLOT_CNT,
  parameter int NUM_PCM   = PCM_CH
) (
  input  logic                         bitClk,
  input  logic                         rstN,
  input  frameStrobe_t                 strb,
  input  logic [SLOT_BITS-1:0]         cmdAddr,
  input  logic                         cmdAddrValid,
  input  logic [SLOT_BITS-1:0]         cmdData,
  input  logic                         cmdDataValid,
  input  logic [NUM_PCM*SLOT_BITS-1:0] pcmData,
  input  logic [NUM_PCM-1:0]           pcmValid,
  output logic                         sdataOut
);
  localparam int FRAME_BITS = TAG_BITS + NUM_SLOTS * SLOT_BITS;

  logic [NUM_SLOTS:1][SLOT_BITS-1:0] slotWord;
  logic [NUM_SLOTS:1]                slotValid;
  logic [TAG_BITS-1:0]               tagVec;
  logic [FRAME_BITS-1:0]             frameVec;
  logic [FRAME_BITS-1:0]             shiftReg;
  logic                              anyValid;

  // place each word in its slot, masked by its flag (zero stuffing)
  always_comb begin
    slotWord  = '0;
    slotValid = '0;
    slotValid[1] = cmdAddrValid;
    slotWord[1]  = cmdAddrValid ? cmdAddr : '0;
    slotValid[2] = cmdDataValid;
    slotWord[2]  = cmdDataValid ? cmdData : '0;
    for (int k = 0; k < NUM_PCM; k++) begin
      slotValid[pcmSlot(k)] = pcmValid[k];
      slotWord[pcmSlot(k)]  = pcmValid[k] ? pcmData[k*SLOT_BITS +: SLOT_BITS] : '0;
    end
  end

  assign anyValid = |slotValid;

  always_comb begin
    tagVec = '0;
    tagVec[TAG_BITS-1] = anyValid;
    for (int s = 1; s <= NUM_SLOTS; s++)
      tagVec[TAG_BITS-1-s] = slotValid[s];
  end

  assign frameVec[FRAME_BITS-1 -: TAG_BITS] = tagVec;

  for (genvar s = 1; s <= NUM_SLOTS; s++) begin : g_slot
    assign frameVec[FRAME_BITS-1-TAG_BITS-(s-1)*SLOT_BITS -: SLOT_BITS] = slotWord[s];
  end

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN)
      shiftReg <= '0;
    else if (strb.load)
      shiftReg <= frameVec;
    else if (strb.shift)
      shiftReg <= {shiftReg[FRAME_BITS-2:0], 1'b0};
  end

  assign sdataOut = shiftReg[FRAME_BITS-1];

  a_r3_frame_flag: assert property (@(posedge bitClk) disable iff (!rstN)
    strb.load |=> (sdataOut == $past(cmdAddrValid | cmdDataValid | (|pcmValid))));
  a_r4_reserved_zero: assert property (@(posedge bitClk) disable iff (!rstN)
    strb.load |=> (shiftReg[FRAME_BITS-TAG_BITS+2 -: 3] == 3'b000));
  a_r7_addr_stuffed: assert property (@(posedge bitClk) disable iff (!rstN)
    (strb.load && !cmdAddrValid) |=>
      (shiftReg[FRAME_BITS-1-TAG_BITS -: SLOT_BITS] == '0));
  a_r8_serial_shift: assert property (@(posedge bitClk) disable iff (!rstN)
    (!strb.load && $past(!strb.load)) |->
      (sdataOut == $past(shiftReg[FRAME_BITS-2])));
endmodule

// File: rtl/tdm_frame_tx.sv
module tdm_frame_tx
  import tdm_frame_pkg::*;
#(
  parameter int TAG_BITS  = TAG_W,
  parameter int SLOT_BITS = SLOT_W,
  parameter int NUM_SLOTS = SLOT_CNT,
  parameter int NUM_PCM   = PCM_CH
) (
  input  logic                         rstN,
  input  logic                         bitClk,
  input  logic [SLOT_BITS-1:0]         cmdAddr,
  input  logic                         cmdAddrValid,
  input  logic [SLOT_BITS-1:0]         cmdData,
  input  logic                         cmdDataValid,
  input  logic [NUM_PCM*SLOT_BITS-1:0] pcmData,
  input  logic [NUM_PCM-1:0]           pcmValid,
  output logic                         syncOut,
  output logic                         sdataOut,
  output logic                         frameStart
);
  localparam int FRAME_BITS = TAG_BITS + NUM_SLOTS * SLOT_BITS;

  frameStrobe_t strb;

  tdm_frame_ctrl #(
    .TAG_BITS  (TAG_BITS),
    .FRAME_BITS(FRAME_BITS)
  ) u_ctrl (
    .bitClk    (bitClk),
    .rstN      (rstN),
    .strb      (strb),
    .syncOut   (syncOut),
    .frameStart(frameStart)
  );

  tdm_frame_dp #(
    .TAG_BITS (TAG_BITS),
    .SLOT_BITS(SLOT_BITS),
    .NUM_SLOTS(NUM_SLOTS),
    .NUM_PCM  (NUM_PCM)
  ) u_dp (
    .bitClk      (bitClk),
    .rstN        (rstN),
    .strb        (strb),
    .cmdAddr     (cmdAddr),
    .cmdAddrValid(cmdAddrValid),
    .cmdData     (cmdData),
    .cmdDataValid(cmdDataValid),
    .pcmData     (pcmData),
    .pcmValid    (pcmValid),
    .sdataOut    (sdataOut)
  );
endmodule

// File: tb/tdm_frame_tx_test.sv
module tdm_frame_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int FB = 256;
  localparam int NF = 14;

  logic        rstN = 1'b0;
  logic        bitClk = 1'b0;
  logic [19:0] cmdAddr = '0, cmdData = '0;
  logic        cmdAddrValid = 1'b0, cmdDataValid = 1'b0;
  logic [79:0] pcmData = '0;
  logic [3:0]  pcmValid = '0;
  logic        syncOut, sdataOut, frameStart;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) bitClk = ~bitClk;

  tdm_frame_tx uut (
    .rstN(rstN), .bitClk(bitClk),
    .cmdAddr(cmdAddr), .cmdAddrValid(cmdAddrValid),
    .cmdData(cmdData), .cmdDataValid(cmdDataValid),
    .pcmData(pcmData), .pcmValid(pcmValid),
    .syncOut(syncOut), .sdataOut(sdataOut), .frameStart(frameStart)
  );

  typedef struct packed {
    logic [19:0] a, d;
    logic        av, dv;
    logic [79:0] p;
    logic [3:0]  pv;
  } stim_t;

  task automatic chk(input string req, input logic [255:0] got, input logic [255:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic int slotPos(input int s);
    return 16 + 20 * (s - 1);  // first serial position of slot s
  endfunction

  // expected 256-bit frame, index 255 = first serial bit
  function automatic logic [255:0] buildFrame(input stim_t st);
    logic [255:0] f = '0;
    logic [12:1] v = '0;
    logic [12:1][19:0] w = '0;
    int ps[4] = '{3, 4, 6, 9};
    v[1] = st.av; w[1] = st.a;
    v[2] = st.dv; w[2] = st.d;
    for (int k = 0; k < 4; k++) begin
      v[ps[k]] = st.pv[k];
      w[ps[k]] = st.p[k*20 +: 20];
    end
    f[255] = |v;
    for (int s = 1; s <= 12; s++) begin
      f[255 - s] = v[s];
      if (v[s])
        for (int b = 0; b < 20; b++)
          f[255 - slotPos(s) - b] = w[s][19 - b];
    end
    return f;
  endfunction

  function automatic logic [19:0] slotOf(input logic [255:0] f, input int s);
    return f[255 - slotPos(s) -: 20];
  endfunction

  task automatic apply(input stim_t st);
    cmdAddr = st.a; cmdAddrValid = st.av;
    cmdData = st.d; cmdDataValid = st.dv;
    pcmData = st.p; pcmValid = st.pv;
  endtask

  function automatic stim_t randStim();
    stim_t st;
    st.a = 20'($urandom); st.d = 20'($urandom);
    st.av = 1'($urandom); st.dv = 1'($urandom);
    st.p = {$urandom, $urandom, $urandom};
    st.pv = 4'($urandom);
    return st;
  endfunction

  function automatic stim_t pickStim(input int f);
    stim_t st = randStim();
    case (f)
      0: begin st.av = 1; st.dv = 1; st.pv = 4'hF; end
      1: begin st.av = 0; st.dv = 0; st.pv = 4'h0;
               st.a = '1; st.d = '1; st.p = '1; end
      2: begin st.av = 1; st.dv = 1; st.pv = 4'h0;
               st.a = 20'hA5A5A; st.d = 20'h80001; end
      3: begin st.av = 0; st.dv = 0; st.pv = 4'b1000;
               st.p = {20'hFFFFF, 20'hFFFFF, 20'hFFFFF, 20'hFFFFF}; end
      4: begin st.av = 0; st.dv = 1; st.pv = 4'b0101;
               st.p = {20'h12345, 20'h0F0F0, 20'h54321, 20'hAAAAA}; end
      default: ;
    endcase
    return st;
  endfunction

  initial begin
    logic [255:0] expCur, expNext, got, syncGot, unusedMask;
    stim_t st;
    void'($urandom(32'd4242));
    repeat (3) @(negedge bitClk);
    // R10: reset state
    chk("R10 reset outputs", {253'd0, syncOut, sdataOut, frameStart}, '0);
    rstN = 1'b1;
    @(negedge bitClk);
    // R10: first frame starts at first edge after release
    chk("R10 first frameStart", {255'd0, frameStart}, {255'd0, 1'b1});
    expCur = '0;  // inputs were all invalid at the first capture
    for (int f = 0; f < NF; f++) begin
      // scramble inputs right after capture: must not touch current frame (R8)
      apply(randStim());
      st = pickStim(f);
      expNext = buildFrame(st);
      got = '0; syncGot = '0;
      for (int p = 0; p < FB; p++) begin
        if (p > 0) begin
          @(negedge bitClk);
          if (frameStart) chk("R9 extra frameStart", {224'd0, 32'(p)}, '0);
        end
        got[255 - p] = sdataOut;
        syncGot[255 - p] = syncOut;
        if (p == 100) apply(st);
      end
      @(negedge bitClk);
      chk("R1 frame period 256", {255'd0, frameStart}, {255'd0, 1'b1});
      chk("R2 sync pattern", syncGot, {16'hFFFF, 240'd0});
      chk("R3 frame valid tag", {255'd0, got[255]}, {255'd0, expCur[255]});
      chk("R4 slot tags", {241'd0, got[254:240]}, {241'd0, expCur[254:240]});
      chk("R5 slot1 cmd address", {236'd0, slotOf(got, 1)}, {236'd0, slotOf(expCur, 1)});
      chk("R5 slot2 cmd data", {236'd0, slotOf(got, 2)}, {236'd0, slotOf(expCur, 2)});
      chk("R6 pcm slots", {176'd0, slotOf(got, 3), slotOf(got, 4), slotOf(got, 6), slotOf(got, 9)},
          {176'd0, slotOf(expCur, 3), slotOf(expCur, 4), slotOf(expCur, 6), slotOf(expCur, 9)});
      unusedMask = '0;
      for (int s = 5; s <= 12; s++)
        if (s != 6 && s != 9)
          for (int b = 0; b < 20; b++) unusedMask[255 - slotPos(s) - b] = 1'b1;
      chk("R7 unused slots zero", got & unusedMask, '0);
      chk("R8 whole frame", got, expCur);
      expCur = expNext;
    end
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge bitClk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired got=hung exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule